// File: doc/BRIEF.md
# Configuration Bitstream Lock Checker

This block sits between a serial configuration port and the configuration loader of a programmable array. It watches a bit-serial input, qualified by a valid strobe, for a 32-bit synchronisation pattern. Once found, it reads a command, a long per-user security identifier, an optional block of configuration data and a 16-bit check code. The identifier is compared bit by bit against a copy held in protected storage, which the block addresses one bit at a time. Only a frame whose identifier matches and whose check code is correct has any effect.

A program frame that passes releases its buffered configuration data to the loader as a short burst of words. A read frame that passes raises a one-cycle grant that opens readback. Any refused frame raises a one-cycle reject, with a separate flag when the check code was wrong. After every frame, refused or not, the block goes back to hunting for the next synchronisation pattern.

Top module: `cfg_lock_checker`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, pay_valid, grant, reject and crc_err are all low.
- R2: Only bits with bit_valid high are consumed. The synchronisation pattern is 32'hAA995566, received most significant bit first, and is recognised at any bit alignment. Bits that come before it have no effect on outputs.
- R3: The 8 bits after the pattern form the command, most significant bit first. 8'hC3 means program: identifier, then 64 payload bits. 8'h3C means read: identifier only. Any other value raises reject for one cycle, in the cycle after the last command bit, and the block returns to hunting.
- R4: The identifier is 1024 bits long. Its k-th received bit (k from 0) is compared with the stored bit presented on id_ref_bit while id_idx equals k. id_ref_bit is a combinational read of storage.
- R5: The check code is CRC-16 with polynomial 0x1021 and seed 0xFFFF. It is computed over the command, identifier and payload bits, shifting each in at the top. It is received as 16 bits, most significant first. A mismatch raises crc_err for one cycle, in the cycle after the last check bit.
- R6: In that same cycle, reject pulses for one cycle if any identifier bit differed or the check code mismatched.
- R7: A read frame with a matching identifier and a correct check code raises grant for exactly one cycle, in the cycle after the last check bit.
- R8: A program frame that passes presents 4 words of 16 bits on pay_data, with pay_valid high on 4 consecutive cycles starting the cycle after the last check bit. The first word holds the first 16 payload bits received, with the earliest bit in the most significant position. A refused frame never raises pay_valid.
- R9: Input bits that arrive while the payload words are being presented are ignored. Hunting then restarts with an empty window, so those bits cannot complete a pattern.
- R10: A frame that starts right after a previous frame has ended (refused, granted or fully released) is processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | bit_in carries a stream bit this cycle |
| bit_in | input | 1 | Serial configuration stream |
| id_idx | output | 10 | Address of the stored identifier bit being compared |
| id_ref_bit | input | 1 | Stored identifier bit at id_idx |
| pay_valid | output | 1 | pay_data holds a released configuration word |
| pay_data | output | 16 | Released configuration word |
| grant | output | 1 | One-cycle readback permission |
| reject | output | 1 | One-cycle frame refusal |
| crc_err | output | 1 | One-cycle check code mismatch flag |

## Verification
The stimulus covers clean program and read frames, both sent with irregular idle gaps in bit_valid and preceded by junk bits. These show that alignment and strobe handling are independent of framing. Single-bit identifier flips at the first and at the last identifier position separate the identifier gate from the check-code gate. A corrupted check code with a good identifier shows that crc_err and reject agree and that no payload escapes. An unknown command shows the early exit. A frame launched during the payload burst, followed by a clean frame, tells apart ignored bits from a stuck or misaligned hunt.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CMD,
        ST_ID,
        ST_PAY,
        ST_CRC,
        ST_DRAIN
    } phase_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam int          CRC_BITS = 16;

    function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic b);
        logic fb;
        fb = cur[15] ^ b;
        return {cur[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_sync_hunt.sv
module cfg_sync_hunt #(
    parameter int               SYNC_BITS = 32,
    parameter logic [SYNC_BITS-1:0] SYNC_WORD = 32'hAA995566
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic din,
    output logic hit
);
    typedef struct packed {
        logic [SYNC_BITS-1:0] win;
    } hunt_t;

    hunt_t hunt_d, hunt_q;
    logic [SYNC_BITS-1:0] win_next;

    assign win_next = {hunt_q.win[SYNC_BITS-2:0], din};
    assign hit      = shift_en && (win_next == SYNC_WORD);

    always_comb begin
        hunt_d = hunt_q;
        if (clear) begin
            hunt_d.win = '0;
        end else if (shift_en) begin
            hunt_d.win = win_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hunt_q <= '0;
        end else begin
            hunt_q <= hunt_d;
        end
    end
endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16
    import cfg_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_load,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);
    typedef struct packed {
        logic [15:0] val;
    } crc_t;

    crc_t crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (seed_load) begin
            crc_d.val = CRC_SEED;
        end else if (en) begin
            crc_d.val = crc_step(crc_q.val, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '{val: CRC_SEED};
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q.val;
endmodule

// File: rtl/cfg_pay_buf.sv
module cfg_pay_buf #(
    parameter int WORD_BITS = 16,
    parameter int PAY_WORDS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_in,
    input  logic                 din,
    input  logic                 pop,
    output logic [WORD_BITS-1:0] word
);
    localparam int PAY_BITS = WORD_BITS * PAY_WORDS;

    typedef struct packed {
        logic [PAY_BITS-1:0] bits;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (shift_in) begin
            buf_d.bits = {buf_q.bits[PAY_BITS-2:0], din};
        end else if (pop) begin
            buf_d.bits = buf_q.bits << WORD_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign word = buf_q.bits[PAY_BITS-1 -: WORD_BITS];
endmodule

// File: rtl/cfg_lock_checker.sv
module cfg_lock_checker
    import cfg_lock_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD = 32'hAA995566,
    parameter int          CMD_BITS  = 8,
    parameter logic [CMD_BITS-1:0] CMD_PROG = 8'hC3,
    parameter logic [CMD_BITS-1:0] CMD_READ = 8'h3C,
    parameter int          ID_BITS   = 1024,
    parameter int          WORD_BITS = 16,
    parameter int          PAY_WORDS = 4,
    localparam int         IDX_W     = $clog2(ID_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_valid,
    input  logic                 bit_in,
    output logic [IDX_W-1:0]     id_idx,
    input  logic                 id_ref_bit,
    output logic                 pay_valid,
    output logic [WORD_BITS-1:0] pay_data,
    output logic                 grant,
    output logic                 reject,
    output logic                 crc_err
);
    localparam int PAY_BITS = WORD_BITS * PAY_WORDS;
    localparam int CNT_LIM  = max_of(max_of(ID_BITS, PAY_BITS),
                                     max_of(max_of(CMD_BITS, CRC_BITS), PAY_WORDS));
    localparam int CNT_W    = $clog2(CNT_LIM) + 1;

    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_ID  = CNT_W'(ID_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_PAY = CNT_W'(PAY_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CRC = CNT_W'(CRC_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_WRD = CNT_W'(PAY_WORDS - 1);

    typedef struct packed {
        phase_e              st;
        logic [CNT_W-1:0]    cnt;
        logic [CMD_BITS-1:0] cmd;
        logic                is_prog;
        logic                mism;
        logic [15:0]         rx_crc;
        logic                grant;
        logic                reject;
        logic                crc_err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic        hunt_clear, hunt_en, hunt_hit;
    logic        crc_seed, crc_en;
    logic [15:0] crc_val;
    logic        buf_shift, buf_pop;
    logic [WORD_BITS-1:0] buf_word;

    cfg_sync_hunt #(
        .SYNC_BITS (32),
        .SYNC_WORD (SYNC_WORD)
    ) u_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hunt_clear),
        .shift_en (hunt_en),
        .din      (bit_in),
        .hit      (hunt_hit)
    );

    cfg_crc16 u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (crc_seed),
        .en        (crc_en),
        .din       (bit_in),
        .crc       (crc_val)
    );

    cfg_pay_buf #(
        .WORD_BITS (WORD_BITS),
        .PAY_WORDS (PAY_WORDS)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_in (buf_shift),
        .din      (bit_in),
        .pop      (buf_pop),
        .word     (buf_word)
    );

    // Datapath enables follow the registered phase
    always_comb begin
        hunt_clear = (ctl_q.st != ST_HUNT);
        hunt_en    = (ctl_q.st == ST_HUNT) && bit_valid;
        crc_seed   = (ctl_q.st == ST_HUNT);
        crc_en     = bit_valid && ((ctl_q.st == ST_CMD) || (ctl_q.st == ST_ID) ||
                                   (ctl_q.st == ST_PAY));
        buf_shift  = bit_valid && (ctl_q.st == ST_PAY);
        buf_pop    = (ctl_q.st == ST_DRAIN);
    end

    // Frame sequencer
    always_comb begin
        logic [CMD_BITS-1:0] cmd_full;
        logic [15:0]         rx_full;
        logic                bad_crc;
        logic                refuse;

        ctl_d         = ctl_q;
        ctl_d.grant   = 1'b0;
        ctl_d.reject  = 1'b0;
        ctl_d.crc_err = 1'b0;
        cmd_full      = {ctl_q.cmd[CMD_BITS-2:0], bit_in};
        rx_full       = {ctl_q.rx_crc[14:0], bit_in};
        bad_crc       = (rx_full != crc_val);
        refuse        = bad_crc || ctl_q.mism;

        unique case (ctl_q.st)
            ST_HUNT: begin
                if (hunt_hit) begin
                    ctl_d.st  = ST_CMD;
                    ctl_d.cnt = '0;
                end
            end
            ST_CMD: begin
                if (bit_valid) begin
                    ctl_d.cmd = cmd_full;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_CMD) begin
                        ctl_d.cnt  = '0;
                        ctl_d.mism = 1'b0;
                        if (cmd_full == CMD_PROG) begin
                            ctl_d.st      = ST_ID;
                            ctl_d.is_prog = 1'b1;
                        end else if (cmd_full == CMD_READ) begin
                            ctl_d.st      = ST_ID;
                            ctl_d.is_prog = 1'b0;
                        end else begin
                            ctl_d.st     = ST_HUNT;
                            ctl_d.reject = 1'b1;
                        end
                    end
                end
            end
            ST_ID: begin
                if (bit_valid) begin
                    ctl_d.mism = ctl_q.mism | (bit_in ^ id_ref_bit);
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_ID) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ctl_q.is_prog ? ST_PAY : ST_CRC;
                    end
                end
            end
            ST_PAY: begin
                if (bit_valid) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_PAY) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_CRC;
                    end
                end
            end
            ST_CRC: begin
                if (bit_valid) begin
                    ctl_d.rx_crc = rx_full;
                    ctl_d.cnt    = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_CRC) begin
                        ctl_d.cnt     = '0;
                        ctl_d.crc_err = bad_crc;
                        ctl_d.reject  = refuse;
                        ctl_d.grant   = !refuse && !ctl_q.is_prog;
                        ctl_d.st      = (!refuse && ctl_q.is_prog) ? ST_DRAIN : ST_HUNT;
                    end
                end
            end
            ST_DRAIN: begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == LAST_WRD) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = ST_HUNT;
                end
            end
            default: begin
                ctl_d.st  = ST_HUNT;
                ctl_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_HUNT, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign id_idx    = (ctl_q.st == ST_ID) ? ctl_q.cnt[IDX_W-1:0] : '0;
    assign pay_valid = (ctl_q.st == ST_DRAIN);
    assign pay_data  = buf_word;
    assign grant     = ctl_q.grant;
    assign reject    = ctl_q.reject;
    assign crc_err   = ctl_q.crc_err;
endmodule

// File: rtl/cfg_lock_checker_sva.sv
module cfg_lock_checker_sva #(
    parameter int PAY_WORDS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic grant,
    input logic reject,
    input logic crc_err,
    input logic pay_valid
);
    localparam int RUN_W = $clog2(PAY_WORDS + 2) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pay_valid) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    p_crc_err_rejects_r5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> reject);

    p_reject_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !reject);

    p_grant_not_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !reject);

    p_grant_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    p_no_payload_after_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !pay_valid);

    p_burst_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (run_q < RUN_W'(PAY_WORDS)));

    p_burst_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pay_valid) |-> (run_q == RUN_W'(PAY_WORDS)));

    p_quiet_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (!grant && !reject && !crc_err));
endmodule

bind cfg_lock_checker cfg_lock_checker_sva #(
    .PAY_WORDS (PAY_WORDS)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .reject    (reject),
    .crc_err   (crc_err),
    .pay_valid (pay_valid)
);

// File: tb/cfg_lock_checker_test.sv
module cfg_lock_checker_test;
    localparam int          ID_BITS  = 1024;
    localparam int          WB       = 16;
    localparam int          NW       = 4;
    localparam logic [31:0] SYNC     = 32'hAA995566;
    localparam logic [7:0]  C_PROG   = 8'hC3;
    localparam logic [7:0]  C_READ   = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic [9:0] id_idx;
    logic id_ref_bit;
    logic pay_valid;
    logic [WB-1:0] pay_data;
    logic grant, reject, crc_err;

    always #10 clk = ~clk;

    logic stored_id [ID_BITS];
    assign id_ref_bit = stored_id[id_idx];

    cfg_lock_checker uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .id_idx(id_idx), .id_ref_bit(id_ref_bit), .pay_valid(pay_valid),
        .pay_data(pay_data), .grant(grant), .reject(reject), .crc_err(crc_err)
    );

    int errors = 0;
    int checks = 0;
    int obs_grant = 0, obs_reject = 0, obs_crc = 0, obs_words = 0;
    bit done = 1'b0;

    // ---------------- reference model ----------------
    int          m_phase = 0;     // 0 hunt, 1 cmd, 2 body, 4 check, 5 burst
    logic [31:0] m_win = '0;
    bit          m_body[$];
    bit          m_rx[$];
    int          m_need = 0;
    bit          m_prog = 1'b0;
    logic [WB-1:0] m_words[$];
    logic e_grant = 0, e_reject = 0, e_crc = 0, e_pv = 0;
    logic [WB-1:0] e_data = '0;

    function automatic logic [15:0] ref_crc(input bit q[$]);
        int c = 16'hFFFF;
        foreach (q[i]) begin
            int top;
            top = ((c >> 15) & 1) ^ int'(q[i]);
            c = (c << 1) & 16'hFFFF;
            if (top != 0) c = c ^ 16'h1021;
        end
        return c[15:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_win = '0; m_words.delete();
            e_grant = 0; e_reject = 0; e_crc = 0; e_pv = 0;
        end else begin
            e_grant = 0; e_reject = 0; e_crc = 0;
            if (m_phase == 5) begin
                void'(m_words.pop_front());
                if (m_words.size() == 0) m_phase = 0;
            end else if (bit_valid) begin
                case (m_phase)
                    0: begin
                        m_win = {m_win[30:0], bit_in};
                        if (m_win == SYNC) begin
                            m_phase = 1; m_body.delete(); m_win = '0;
                        end
                    end
                    1: begin
                        m_body.push_back(bit_in);
                        if (m_body.size() == 8) begin
                            logic [7:0] cv;
                            for (int i = 0; i < 8; i++) cv[7-i] = m_body[i];
                            if (cv == C_PROG) begin
                                m_prog = 1; m_need = 8 + ID_BITS + WB*NW; m_phase = 2;
                            end else if (cv == C_READ) begin
                                m_prog = 0; m_need = 8 + ID_BITS; m_phase = 2;
                            end else begin
                                e_reject = 1; m_phase = 0;
                            end
                        end
                    end
                    2: begin
                        m_body.push_back(bit_in);
                        if (m_body.size() == m_need) begin
                            m_phase = 4; m_rx.delete();
                        end
                    end
                    4: begin
                        m_rx.push_back(bit_in);
                        if (m_rx.size() == 16) begin
                            logic [15:0] rv;
                            bit idok;
                            for (int i = 0; i < 16; i++) rv[15-i] = m_rx[i];
                            idok = 1;
                            for (int k = 0; k < ID_BITS; k++)
                                if (m_body[8+k] != stored_id[k]) idok = 0;
                            e_crc = (rv != ref_crc(m_body));
                            e_reject = e_crc || !idok;
                            e_grant = !e_reject && !m_prog;
                            m_phase = 0;
                            if (!e_reject && m_prog) begin
                                for (int w = 0; w < NW; w++) begin
                                    logic [WB-1:0] wv;
                                    for (int b = 0; b < WB; b++)
                                        wv[WB-1-b] = m_body[8 + ID_BITS + w*WB + b];
                                    m_words.push_back(wv);
                                end
                                m_phase = 5;
                            end
                        end
                    end
                    default: m_phase = 0;
                endcase
            end
            e_pv = (m_phase == 5);
            if (e_pv) e_data = m_words[0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1 reset outputs", {28'd0, pay_valid, grant, reject, crc_err}, 32'd0);
            end else begin
                chk("R7 grant", {31'd0, grant}, {31'd0, e_grant});
                chk("R6 reject", {31'd0, reject}, {31'd0, e_reject});
                chk("R5 crc_err", {31'd0, crc_err}, {31'd0, e_crc});
                chk("R8 pay_valid", {31'd0, pay_valid}, {31'd0, e_pv});
                if (e_pv) chk("R8 pay_data", {16'd0, pay_data}, {16'd0, e_data});
                obs_grant  += int'(grant);
                obs_reject += int'(reject);
                obs_crc    += int'(crc_err);
                obs_words  += int'(pay_valid);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    bit q_tx[$];
    int gap_ctr = 0;

    task automatic add_frame(input logic [7:0] cmd, input bit with_pay, input int flip,
                             input bit bad_crc, input logic [63:0] pay);
        bit body[$];
        logic [15:0] c;
        for (int i = 31; i >= 0; i--) q_tx.push_back(SYNC[i]);
        for (int i = 7; i >= 0; i--) body.push_back(cmd[i]);
        if (cmd == C_PROG || cmd == C_READ) begin
            for (int k = 0; k < ID_BITS; k++) body.push_back(stored_id[k] ^ (k == flip));
            if (with_pay) for (int i = 63; i >= 0; i--) body.push_back(pay[i]);
            c = ref_crc(body);
            if (bad_crc) c = c ^ 16'h0001;
            foreach (body[i]) q_tx.push_back(body[i]);
            for (int i = 15; i >= 0; i--) q_tx.push_back(c[i]);
        end else begin
            foreach (body[i]) q_tx.push_back(body[i]);
        end
    endtask

    task automatic send(input bit gaps);
        foreach (q_tx[i]) begin
            @(negedge clk);
            if (gaps) begin
                gap_ctr++;
                if ((gap_ctr % 7) == 3) begin
                    bit_valid = 0;
                    @(negedge clk);
                end
            end
            bit_valid = 1; bit_in = q_tx[i];
        end
        @(negedge clk);
        bit_valid = 0;
        q_tx.delete();
        repeat (10) @(negedge clk);
    endtask

    int sg, sr, sc, sw;
    task automatic snap();
        sg = obs_grant; sr = obs_reject; sc = obs_crc; sw = obs_words;
    endtask
    task automatic expect_cnt(input string tag, input int g, input int r, input int c, input int w);
        chk({tag, " grants"},  obs_grant - sg,  g);
        chk({tag, " rejects"}, obs_reject - sr, r);
        chk({tag, " crc errs"}, obs_crc - sc,   c);
        chk({tag, " words"},   obs_words - sw,  w);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int k = 0; k < ID_BITS; k++) begin
            stored_id[k] = lf[0];
            lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 first cycle idle", {28'd0, pay_valid, grant, reject, crc_err}, 32'd0);

        // R2 R8: junk then program frame, with gaps
        snap();
        for (int i = 0; i < 13; i++) q_tx.push_back(i[0] ^ i[2]);
        for (int i = 31; i >= 4; i--) q_tx.push_back(SYNC[i]);
        add_frame(C_PROG, 1, -1, 0, 64'h1234_5678_9ABC_DEF0);
        send(1);
        expect_cnt("R2 R8 program", 0, 0, 0, NW);

        // R7 read, clean
        snap(); add_frame(C_READ, 0, -1, 0, '0); send(0);
        expect_cnt("R7 read", 1, 0, 0, 0);

        // R4 R6 identifier flips
        snap(); add_frame(C_READ, 0, ID_BITS - 1, 0, '0); send(1);
        expect_cnt("R4 R6 last id bit", 0, 1, 0, 0);
        snap(); add_frame(C_PROG, 1, 0, 0, 64'hFFFF_0000_A5A5_5A5A); send(0);
        expect_cnt("R4 R6 R8 first id bit", 0, 1, 0, 0);

        // R5 bad check code on program
        snap(); add_frame(C_PROG, 1, -1, 1, 64'h0F0F_F0F0_3333_CCCC); send(0);
        expect_cnt("R5 R8 bad crc", 0, 1, 1, 0);

        // R3 unknown command
        snap(); add_frame(8'h99, 0, -1, 0, '0); send(0);
        expect_cnt("R3 unknown cmd", 0, 1, 0, 0);

        // R9 frame launched into burst, then R10 back-to-back clean frames
        snap();
        add_frame(C_PROG, 1, -1, 0, 64'hDEAD_BEEF_0123_4567);
        add_frame(C_READ, 0, -1, 0, '0);
        send(0);
        expect_cnt("R9 bits during burst", 0, 0, 0, NW);
        snap();
        add_frame(C_READ, 0, 5, 0, '0);
        add_frame(C_READ, 0, -1, 0, '0);
        send(1);
        expect_cnt("R10 back to back", 1, 1, 0, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule